// File: doc/BRIEF.md
# Serial FIFO Extension Interrupt Controller

This block is the register and interrupt front end placed between a 16550-style UART and a pair of deep byte FIFOs. Software reaches it through a byte-wide window of eight offsets. The window holds the mode settings, the interrupt mask, a status byte, a FIFO flush strobe, an interval value and a timer control strobe. It also has a data port. A read of the data port pops the receive FIFO, and a write to it pushes the transmit FIFO. The UART side pushes received bytes and pops bytes to transmit through its own single-cycle strobes.

Five interrupt sources are held in the block: receive half-full, character timeout, transmit empty, transmit half-full and a programmable interval timer. Each source is cleared by a side effect of normal traffic, not by a dedicated acknowledge register. Those side effects are a status read, draining or filling a FIFO across its half mark, or turning the timer off. The enabled sources are ORed onto one interrupt pin. The pin either follows that OR (level type) or pulses for one cycle when the OR rises (edge type).

Top module: `sfx_irq_ctrl`

## Requirements
- R1: After reset, offset 0 reads 0x04, offsets 1 and 3 read 0x00, status (offset 2) reads 0x29, irq is low, flow_ctl_en is low and ext_fifo_en is high.
- R2: Offset 0 holds level-type (bit4), flow control (bit3), FIFO enable (bit2) and byte swap (bit0); bits 7:5 and 1 read 0. Offset 1 holds enables in bits 4:0 and reads 0 above. Offset 3 reads back all 8 bits. Offsets 4, 6 and 7 read 0. flow_ctl_en and ext_fifo_en mirror bits 3 and 2.
- R3: The status byte is: bit7 timer pending, bit6 character timeout pending, bit5 receive full (active low, 0 when 16 bytes held), bit4 receive holds 8 or more, bit3 receive empty, bit2 transmit full, bit1 transmit holds 8 or more, bit0 transmit empty.
- R4: The receive half-full source (enable bit0) is active while the receive FIFO holds 8 or more bytes. It drops once data-port reads take it below 8.
- R5: A pulse on char_tmo_evt sets the character timeout source (enable bit3). A status read or a data-port read that pops a byte clears it.
- R6: A UART pop that empties the transmit FIFO sets the transmit empty source (enable bit2). A data-port write that is accepted, or a status read, clears it.
- R7: A UART pop that takes the transmit FIFO from 8 to 7 bytes sets the transmit half-full source (enable bit1). A write that takes it back to 8, or a status read, clears it.
- R8: Writing offset 4 with bit0=1 starts the timer with the interval n held at offset 3. The timer source (enable bit4) sets n×TICK_DIV cycles after that write. It stays set until offset 4 is written with bit0=0. An interval of 0 never sets it.
- R9: irq is the OR of the enabled sources when offset-0 bit4 is 1. It is a one-cycle pulse on each rise of that OR when bit4 is 0. irq stays low while all enables are 0.
- R10: A write to offset 2 flushes the receive FIFO when bit0 is set and the transmit FIFO when bit1 is set, within that cycle.
- R11: With byte swap set, the bus-side FIFO index is XORed with 8. Sixteen bytes queued by the UART are then read back starting with the ninth. Sixteen bytes written by the bus are popped starting with the ninth.
- R12: Data-port reads return bytes in arrival order and pop only when the receive FIFO is not empty. Pushes into a full FIFO are dropped, and uart_tx_data shows the oldest transmit byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 write, 0 read |
| bus_addr | input | 3 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |
| uart_rx_push | input | 1 | UART pushes a received byte |
| uart_rx_data | input | 8 | Received byte |
| uart_tx_pop | input | 1 | UART takes the oldest transmit byte |
| uart_tx_data | output | 8 | Oldest transmit byte |
| uart_tx_avail | output | 1 | Transmit FIFO not empty |
| char_tmo_evt | input | 1 | Character timeout event pulse from the receive path |
| irq | output | 1 | Interrupt request |
| flow_ctl_en | output | 1 | Automatic RTS/CTS flow control enable |
| ext_fifo_en | output | 1 | Deep FIFO enable |

## Verification
A pending flag that is stuck or cleared too early shows in the status byte or on irq in the cycle after the edge that should have changed it. The bench samples at that cycle, so an off-by-one in a clear rule or in the timer expiry is seen at once. A wrong FIFO pointer or swap index shows as a wrong byte on the first read or pop after the fill. A count error shows as a wrong half, full or empty bit on the next status read.

// File: rtl/sfx_pkg.sv
// Shared definitions for the serial FIFO extension interrupt controller.
// Assumes an 8-bit register bus and a 3-bit offset space.
package sfx_pkg;
    localparam int REG_W  = 8;
    localparam int ADDR_W = 3;

    // Register offsets of the byte window
    typedef enum logic [ADDR_W-1:0] {
        ADR_MODE     = 3'd0,
        ADR_IRQ_EN   = 3'd1,
        ADR_STATUS   = 3'd2,
        ADR_INTERVAL = 3'd3,
        ADR_TMR_CTL  = 3'd4,
        ADR_DATA     = 3'd5
    } sfx_addr_e;

    // Interrupt source index, equal to its bit in the enable register
    localparam int SRC_RX_HALF  = 0;
    localparam int SRC_TX_HALF  = 1;
    localparam int SRC_TX_EMPTY = 2;
    localparam int SRC_CHAR_TMO = 3;
    localparam int SRC_TIMER    = 4;
    localparam int NUM_SRC      = 5;

    // Mode register bit positions
    localparam int MODE_SWAP  = 0;
    localparam int MODE_EXT   = 2;
    localparam int MODE_FLOW  = 3;
    localparam int MODE_LEVEL = 4;

    typedef struct packed {
        logic level;
        logic flow;
        logic ext;
        logic swap;
    } sfx_mode_t;
endpackage

// File: rtl/sfx_fifo.sv
// Byte FIFO with occupancy count and optional half swap of either index.
// Assumes DEPTH is a power of two and at least 2. Flush wins over push and
// pop in the same cycle. Push when full and pop when empty are dropped.
module sfx_fifo #(
    parameter int DEPTH = 16,
    parameter int W     = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     flush,
    input  logic                     push,
    input  logic [W-1:0]             din,
    input  logic                     pop,
    input  logic                     wr_swap,
    input  logic                     rd_swap,
    output logic [W-1:0]             head,
    output logic [$clog2(DEPTH):0]   count
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;
    localparam logic [CW-1:0] CNT_FULL = CW'(DEPTH);
    localparam logic [AW-1:0] HALF_OFS = AW'(DEPTH / 2);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr;
    logic [AW-1:0] rd_ptr;
    logic [AW-1:0] wr_idx;
    logic [AW-1:0] rd_idx;
    logic          push_ok;
    logic          pop_ok;

    assign push_ok = push && (count != CNT_FULL);
    assign pop_ok  = pop && (count != '0);
    assign wr_idx  = wr_ptr ^ (wr_swap ? HALF_OFS : '0);
    assign rd_idx  = rd_ptr ^ (rd_swap ? HALF_OFS : '0);
    assign head    = mem[rd_idx];

    // Pointer and occupancy bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok) wr_ptr <= wr_ptr + 1'b1;
            if (pop_ok)  rd_ptr <= rd_ptr + 1'b1;
            case ({push_ok, pop_ok})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // Storage write, no reset needed on data
    always_ff @(posedge clk) begin
        if (push_ok && !flush) mem[wr_idx] <= din;
    end
endmodule

// File: rtl/sfx_interval_timer.sv
// Interval timer: a prescaler makes one tick every TICK_DIV cycles, and a
// down counter loaded with the interval expires after that many ticks.
// Expiry latches pend and reloads. Only a disabling control write clears
// pend. An interval of zero never expires.
module sfx_interval_timer #(
    parameter int TICK_DIV = 10000,
    parameter int VAL_W    = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_wr,
    input  logic             ctl_run,
    input  logic [VAL_W-1:0] interval,
    output logic             pend
);
    localparam int PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam logic [PW-1:0] PRE_LAST = PW'(TICK_DIV - 1);
    localparam logic [VAL_W-1:0] CNT_LAST = VAL_W'(1);

    logic             running;
    logic [PW-1:0]    pre;
    logic [VAL_W-1:0] remain;

    // Start, stop, prescale and count down
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running <= 1'b0;
            pre     <= '0;
            remain  <= '0;
            pend    <= 1'b0;
        end else if (ctl_wr) begin
            if (!ctl_run) begin
                running <= 1'b0;
                pend    <= 1'b0;
            end else if (!running) begin
                running <= 1'b1;
                pre     <= '0;
                remain  <= interval;
            end
        end else if (running) begin
            if (pre == PRE_LAST) begin
                pre <= '0;
                if (remain == CNT_LAST) begin
                    pend   <= 1'b1;
                    remain <= interval;
                end else if (remain != '0) begin
                    remain <= remain - 1'b1;
                end
            end else begin
                pre <= pre + 1'b1;
            end
        end
    end
endmodule

// File: rtl/sfx_irq_core.sv
// Holds the latched interrupt sources, applies the enable mask and forms
// the level or edge interrupt output. Accepted push/pop strobes and the
// transmit count before the edge come from the top.
module sfx_irq_core
    import sfx_pkg::*;
#(
    parameter int CW   = 5,
    parameter int HALF = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] ie,
    input  logic               level,
    input  logic               stat_rd,
    input  logic               rx_pop_ok,
    input  logic               char_tmo_evt,
    input  logic               tx_pop_ok,
    input  logic               tx_push_ok,
    input  logic [CW-1:0]      tx_cnt,
    input  logic               rx_half,
    input  logic               tmr_pend,
    output logic               ctmo_pend,
    output logic               irq
);
    localparam logic [CW-1:0] CNT_ONE   = CW'(1);
    localparam logic [CW-1:0] CNT_HALF  = CW'(HALF);
    localparam logic [CW-1:0] CNT_BELOW = CW'(HALF - 1);

    logic               txe_pend;
    logic               txh_pend;
    logic [NUM_SRC-1:0] src;
    logic [NUM_SRC-1:0] gated;
    logic               req;
    logic               req_q;

    // Character timeout: event sets, status or data read clears
    always_ff @(posedge clk) begin
        if (!rst_n)                     ctmo_pend <= 1'b0;
        else if (char_tmo_evt)          ctmo_pend <= 1'b1;
        else if (stat_rd || rx_pop_ok)  ctmo_pend <= 1'b0;
    end

    // Transmit empty: last byte popped sets, write or status read clears
    always_ff @(posedge clk) begin
        if (!rst_n)
            txe_pend <= 1'b0;
        else if (tx_pop_ok && !tx_push_ok && tx_cnt == CNT_ONE)
            txe_pend <= 1'b1;
        else if (tx_push_ok || stat_rd)
            txe_pend <= 1'b0;
    end

    // Transmit half-full: drop below half sets, refill or status read clears
    always_ff @(posedge clk) begin
        if (!rst_n)
            txh_pend <= 1'b0;
        else if (tx_pop_ok && !tx_push_ok && tx_cnt == CNT_HALF)
            txh_pend <= 1'b1;
        else if ((tx_push_ok && !tx_pop_ok && tx_cnt == CNT_BELOW) || stat_rd)
            txh_pend <= 1'b0;
    end

    always_comb begin
        src               = '0;
        src[SRC_RX_HALF]  = rx_half;
        src[SRC_TX_HALF]  = txh_pend;
        src[SRC_TX_EMPTY] = txe_pend;
        src[SRC_CHAR_TMO] = ctmo_pend;
        src[SRC_TIMER]    = tmr_pend;
    end

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_mask
        assign gated[g] = src[g] & ie[g];
    end

    assign req = |gated;

    // Previous request, for rising-edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) req_q <= 1'b0;
        else        req_q <= req;
    end

    assign irq = level ? req : (req & ~req_q);
endmodule

// File: rtl/sfx_irq_ctrl.sv
// Top of the serial FIFO extension interrupt controller. It decodes the
// byte register window, holds the mode, enable and interval registers,
// instances both FIFOs, the interval timer and the interrupt core.
// Assumes one bus access per cycle, signalled by bus_sel.
module sfx_irq_ctrl
    import sfx_pkg::*;
#(
    parameter int FIFO_DEPTH = 16,
    parameter int TICK_DIV   = 10000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    input  logic              uart_rx_push,
    input  logic [REG_W-1:0]  uart_rx_data,
    input  logic              uart_tx_pop,
    output logic [REG_W-1:0]  uart_tx_data,
    output logic              uart_tx_avail,
    input  logic              char_tmo_evt,
    output logic              irq,
    output logic              flow_ctl_en,
    output logic              ext_fifo_en
);
    localparam int CW   = $clog2(FIFO_DEPTH) + 1;
    localparam int HALF = FIFO_DEPTH / 2;
    localparam logic [CW-1:0] CNT_FULL = CW'(FIFO_DEPTH);
    localparam logic [CW-1:0] CNT_HALF = CW'(HALF);

    sfx_mode_t          mode_q;
    logic [NUM_SRC-1:0] ie_q;
    logic [REG_W-1:0]   intv_q;

    logic rd_acc, wr_acc;
    logic stat_rd, data_rd, data_wr, mode_wr, ie_wr, intv_wr, tcr_wr, frr_wr;
    logic rx_flush, tx_flush;

    logic [REG_W-1:0] rx_head;
    logic [CW-1:0]    rx_cnt, tx_cnt;
    logic rx_full, rx_half, rx_empty, tx_full, tx_half, tx_empty;
    logic rx_pop_ok, tx_pop_ok, tx_push_ok;
    logic tmr_pend, ctmo_pend;

    // Access decode
    assign rd_acc   = bus_sel && !bus_wr;
    assign wr_acc   = bus_sel && bus_wr;
    assign stat_rd  = rd_acc && (bus_addr == ADR_STATUS);
    assign data_rd  = rd_acc && (bus_addr == ADR_DATA);
    assign data_wr  = wr_acc && (bus_addr == ADR_DATA);
    assign mode_wr  = wr_acc && (bus_addr == ADR_MODE);
    assign ie_wr    = wr_acc && (bus_addr == ADR_IRQ_EN);
    assign intv_wr  = wr_acc && (bus_addr == ADR_INTERVAL);
    assign tcr_wr   = wr_acc && (bus_addr == ADR_TMR_CTL);
    assign frr_wr   = wr_acc && (bus_addr == ADR_STATUS);
    assign rx_flush = frr_wr && bus_wdata[0];
    assign tx_flush = frr_wr && bus_wdata[1];

    // FIFO level flags
    assign rx_full  = (rx_cnt == CNT_FULL);
    assign rx_half  = (rx_cnt >= CNT_HALF);
    assign rx_empty = (rx_cnt == '0);
    assign tx_full  = (tx_cnt == CNT_FULL);
    assign tx_half  = (tx_cnt >= CNT_HALF);
    assign tx_empty = (tx_cnt == '0);

    assign rx_pop_ok  = data_rd && !rx_empty;
    assign tx_push_ok = data_wr && !tx_full;
    assign tx_pop_ok  = uart_tx_pop && !tx_empty;

    // Mode, enable and interval registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= '{level: 1'b0, flow: 1'b0, ext: 1'b1, swap: 1'b0};
            ie_q   <= '0;
            intv_q <= '0;
        end else begin
            if (mode_wr) begin
                mode_q.level <= bus_wdata[MODE_LEVEL];
                mode_q.flow  <= bus_wdata[MODE_FLOW];
                mode_q.ext   <= bus_wdata[MODE_EXT];
                mode_q.swap  <= bus_wdata[MODE_SWAP];
            end
            if (ie_wr)   ie_q   <= bus_wdata[NUM_SRC-1:0];
            if (intv_wr) intv_q <= bus_wdata;
        end
    end

    // Read data multiplexer
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            ADR_MODE: begin
                bus_rdata[MODE_LEVEL] = mode_q.level;
                bus_rdata[MODE_FLOW]  = mode_q.flow;
                bus_rdata[MODE_EXT]   = mode_q.ext;
                bus_rdata[MODE_SWAP]  = mode_q.swap;
            end
            ADR_IRQ_EN:   bus_rdata[NUM_SRC-1:0] = ie_q;
            ADR_STATUS:   bus_rdata = {tmr_pend, ctmo_pend, ~rx_full, rx_half,
                                       rx_empty, tx_full, tx_half, tx_empty};
            ADR_INTERVAL: bus_rdata = intv_q;
            ADR_DATA:     bus_rdata = rx_head;
            default:      bus_rdata = '0;
        endcase
    end

    assign flow_ctl_en   = mode_q.flow;
    assign ext_fifo_en   = mode_q.ext;
    assign uart_tx_avail = !tx_empty;

    sfx_fifo #(.DEPTH(FIFO_DEPTH), .W(REG_W)) u_rx_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush   (rx_flush),
        .push    (uart_rx_push),
        .din     (uart_rx_data),
        .pop     (data_rd),
        .wr_swap (1'b0),
        .rd_swap (mode_q.swap),
        .head    (rx_head),
        .count   (rx_cnt)
    );

    sfx_fifo #(.DEPTH(FIFO_DEPTH), .W(REG_W)) u_tx_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush   (tx_flush),
        .push    (data_wr),
        .din     (bus_wdata),
        .pop     (uart_tx_pop),
        .wr_swap (mode_q.swap),
        .rd_swap (1'b0),
        .head    (uart_tx_data),
        .count   (tx_cnt)
    );

    sfx_interval_timer #(.TICK_DIV(TICK_DIV), .VAL_W(REG_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctl_wr   (tcr_wr),
        .ctl_run  (bus_wdata[0]),
        .interval (intv_q),
        .pend     (tmr_pend)
    );

    sfx_irq_core #(.CW(CW), .HALF(HALF)) u_core (
        .clk          (clk),
        .rst_n        (rst_n),
        .ie           (ie_q),
        .level        (mode_q.level),
        .stat_rd      (stat_rd),
        .rx_pop_ok    (rx_pop_ok),
        .char_tmo_evt (char_tmo_evt),
        .tx_pop_ok    (tx_pop_ok),
        .tx_push_ok   (tx_push_ok),
        .tx_cnt       (tx_cnt),
        .rx_half      (rx_half),
        .tmr_pend     (tmr_pend),
        .ctmo_pend    (ctmo_pend),
        .irq          (irq)
    );
endmodule

// File: rtl/sfx_irq_ctrl_chk.sv
// Property checker for sfx_irq_ctrl, attached through bind.
module sfx_irq_ctrl_chk #(
    parameter int CW = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic          irq,
    input logic          lvl,
    input logic [4:0]    ie,
    input logic          tmr_pend,
    input logic          tcr_wr,
    input logic          wbit0,
    input logic          stat_rd,
    input logic          tx_pop,
    input logic          frr_rx,
    input logic [CW-1:0] rx_cnt,
    input logic [2:0]    bus_addr,
    input logic          rd_bit1
);
    AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == 3'd0) |-> (rd_bit1 == 1'b0)); // R2

    AST_STATUS_CLEARS_TX: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && !tx_pop && ie[4:3] == 2'b00 && !ie[0]) |=> !irq); // R6

    AST_TIMER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_pend && !(tcr_wr && !wbit0)) |=> tmr_pend); // R8

    AST_TIMER_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (tcr_wr && !wbit0) |=> !tmr_pend); // R8

    AST_EDGE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (!lvl && irq) |=> (!irq || lvl)); // R9

    AST_MASK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (ie == 5'b00000) |-> !irq); // R9

    AST_RX_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        frr_rx |=> (rx_cnt == '0)); // R10
endmodule

bind sfx_irq_ctrl sfx_irq_ctrl_chk #(.CW(CW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .irq      (irq),
    .lvl      (mode_q.level),
    .ie       (ie_q),
    .tmr_pend (tmr_pend),
    .tcr_wr   (tcr_wr),
    .wbit0    (bus_wdata[0]),
    .stat_rd  (stat_rd),
    .tx_pop   (uart_tx_pop),
    .frr_rx   (rx_flush),
    .rx_cnt   (rx_cnt),
    .bus_addr (bus_addr),
    .rd_bit1  (bus_rdata[1])
);

// File: tb/test_sfx_irq_ctrl.sv
`timescale 1ns/1ps
// Self-checking bench: register vector table, then directed tests.
module test_sfx_irq_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_sel = 1'b0;
    logic       bus_wr = 1'b0;
    logic [2:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       uart_rx_push = 1'b0;
    logic [7:0] uart_rx_data = '0;
    logic       uart_tx_pop = 1'b0;
    logic [7:0] uart_tx_data;
    logic       uart_tx_avail;
    logic       char_tmo_evt = 1'b0;
    logic       irq;
    logic       flow_ctl_en;
    logic       ext_fifo_en;

    int checks = 0;
    int fails  = 0;
    logic [7:0] rd;

    always #2 clk = ~clk;

    sfx_irq_ctrl #(.FIFO_DEPTH(16), .TICK_DIV(4)) i_sfx_irq_ctrl (.*);

    // {write, addr[2:0], data}: data is write value or expected read value
    localparam int NVEC = 15;
    localparam logic [11:0] VEC [NVEC] = '{
        12'h8FF, 12'h01D, 12'h804, 12'h004, 12'h9FF, 12'h11F, 12'h900,
        12'h100, 12'hBA5, 12'h3A5, 12'hB00, 12'h300, 12'h400, 12'h600,
        12'h700
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic peek(input logic [2:0] a, output logic [7:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic rx_push(input logic [7:0] d);
        @(negedge clk);
        uart_rx_push = 1'b1; uart_rx_data = d;
        @(negedge clk);
        uart_rx_push = 1'b0;
    endtask

    task automatic tx_pop(input string req, input logic [7:0] exp);
        @(negedge clk);
        #1 check(req, uart_tx_data, exp);
        uart_tx_pop = 1'b1;
        @(negedge clk);
        uart_tx_pop = 1'b0;
    endtask

    task automatic tmo_pulse();
        @(negedge clk);
        char_tmo_evt = 1'b1;
        @(negedge clk);
        char_tmo_evt = 1'b0;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        peek(3'd0, rd); check("R1 mode", rd, 8'h04);
        peek(3'd1, rd); check("R1 enable", rd, 8'h00);
        peek(3'd2, rd); check("R1 status", rd, 8'h29);
        peek(3'd3, rd); check("R1 interval", rd, 8'h00);
        check("R1 irq", {7'b0, irq}, 8'h00);
        check("R1 pins", {6'b0, flow_ctl_en, ext_fifo_en}, 8'h01);

        // R2 register vector table
        for (int i = 0; i < NVEC; i++) begin
            if (VEC[i][11]) begin
                bus_write(VEC[i][10:8], VEC[i][7:0]);
            end else begin
                bus_read(VEC[i][10:8], rd);
                check("R2 table", rd, VEC[i][7:0]);
            end
        end
        bus_write(3'd0, 8'h0C);
        check("R2 flow pin", {7'b0, flow_ctl_en}, 8'h01);
        bus_write(3'd0, 8'h04);

        // R3 R4 R12 receive path, level irq (R9)
        for (int i = 0; i < 16; i++) rx_push(8'h10 + 8'(i));
        peek(3'd2, rd); check("R3 rx full status", rd, 8'h11);
        rx_push(8'hEE);
        bus_write(3'd0, 8'h14);
        bus_write(3'd1, 8'h01);
        check("R9 level irq", {7'b0, irq}, 8'h01);
        for (int i = 0; i < 9; i++) begin
            bus_read(3'd5, rd); check("R12 rx order", rd, 8'h10 + 8'(i));
            if (i == 7) check("R4 still half", {7'b0, irq}, 8'h01);
        end
        check("R4 below half", {7'b0, irq}, 8'h00);
        peek(3'd2, rd); check("R3 rx partial", rd, 8'h21);
        for (int i = 9; i < 16; i++) begin
            bus_read(3'd5, rd); check("R12 rx order", rd, 8'h10 + 8'(i));
        end
        bus_read(3'd5, rd);
        peek(3'd2, rd); check("R12 rx empty", rd, 8'h29);

        // R9 edge pulse, R10 receive flush
        bus_write(3'd0, 8'h04);
        for (int i = 0; i < 7; i++) rx_push(8'(i));
        check("R9 edge idle", {7'b0, irq}, 8'h00);
        rx_push(8'h07);
        check("R9 edge pulse", {7'b0, irq}, 8'h01);
        @(negedge clk);
        check("R9 edge end", {7'b0, irq}, 8'h00);
        bus_write(3'd2, 8'h01);
        peek(3'd2, rd); check("R10 rx flush", rd, 8'h29);

        // R5 character timeout
        bus_write(3'd0, 8'h14);
        bus_write(3'd1, 8'h08);
        tmo_pulse();
        peek(3'd2, rd); check("R5 set", rd, 8'h69);
        check("R5 irq", {7'b0, irq}, 8'h01);
        bus_read(3'd2, rd); check("R5 status read", rd, 8'h69);
        peek(3'd2, rd); check("R5 cleared by status", rd, 8'h29);
        check("R5 irq low", {7'b0, irq}, 8'h00);
        tmo_pulse();
        rx_push(8'h77);
        bus_read(3'd5, rd); check("R12 single", rd, 8'h77);
        peek(3'd2, rd); check("R5 cleared by data", rd, 8'h29);

        // R6 R7 transmit sources
        bus_write(3'd1, 8'h06);
        for (int i = 0; i < 16; i++) bus_write(3'd5, 8'hA0 + 8'(i));
        peek(3'd2, rd); check("R3 tx full status", rd, 8'h2E);
        bus_write(3'd5, 8'hFF);
        for (int i = 0; i < 8; i++) tx_pop("R12 tx order", 8'hA0 + 8'(i));
        check("R7 at half", {7'b0, irq}, 8'h00);
        tx_pop("R12 tx order", 8'hA8);
        check("R7 set", {7'b0, irq}, 8'h01);
        bus_read(3'd2, rd);
        check("R7 status clear", {7'b0, irq}, 8'h00);
        for (int i = 9; i < 16; i++) tx_pop("R12 tx order", 8'hA0 + 8'(i));
        check("R6 set", {7'b0, irq}, 8'h01);
        bus_write(3'd5, 8'h55);
        check("R6 write clear", {7'b0, irq}, 8'h00);
        for (int i = 0; i < 7; i++) bus_write(3'd5, 8'h56 + 8'(i));
        tx_pop("R12 tx head", 8'h55);
        check("R7 set again", {7'b0, irq}, 8'h01);
        bus_write(3'd5, 8'h60);
        check("R7 refill clear", {7'b0, irq}, 8'h00);
        bus_write(3'd2, 8'h02);
        peek(3'd2, rd); check("R10 tx flush", rd, 8'h29);

        // R8 interval timer, n=3, TICK_DIV=4: expiry 12 cycles after write
        bus_write(3'd1, 8'h10);
        bus_write(3'd3, 8'h03);
        bus_write(3'd4, 8'h01);
        repeat (11) @(negedge clk);
        peek(3'd2, rd); check("R8 before expiry", rd, 8'h29);
        @(negedge clk);
        peek(3'd2, rd); check("R8 expiry", rd, 8'hA9);
        check("R8 irq", {7'b0, irq}, 8'h01);
        repeat (20) @(negedge clk);
        bus_read(3'd2, rd); check("R8 held", rd, 8'hA9);
        bus_write(3'd4, 8'h00);
        peek(3'd2, rd); check("R8 disable clear", rd, 8'h29);
        check("R8 irq low", {7'b0, irq}, 8'h00);
        peek(3'd4, rd); check("R2 control reads zero", rd, 8'h00);
        bus_write(3'd3, 8'h00);
        bus_write(3'd4, 8'h01);
        repeat (60) @(negedge clk);
        peek(3'd2, rd); check("R8 zero interval", rd, 8'h29);
        bus_write(3'd4, 8'h00);

        // R11 swap of bus-side index
        bus_write(3'd1, 8'h00);
        bus_write(3'd2, 8'h03);
        bus_write(3'd0, 8'h05);
        for (int i = 0; i < 16; i++) rx_push(8'h40 + 8'(i));
        bus_read(3'd5, rd); check("R11 rx swap", rd, 8'h48);
        bus_read(3'd5, rd); check("R11 rx swap next", rd, 8'h49);
        for (int i = 0; i < 16; i++) bus_write(3'd5, 8'h60 + 8'(i));
        tx_pop("R11 tx swap", 8'h68);
        bus_write(3'd2, 8'h03);
        bus_write(3'd0, 8'h04);
        peek(3'd2, rd); check("R10 both flush", rd, 8'h29);

        finish_run();
    end
endmodule